// File: doc/BRIEF.md
# Multiplexed-Address Small Static RAM

A 64-word by 8-bit static memory model for a processor bus whose address arrives in two halves over the same pins. A dual-purpose pin, `selAddrPin`, can be captured while the address strobe `addrStrobe` is high. That captured bit comes from the high address half and is then used as a chip select during the access. If the strobe is instead held high all the time, the same pin acts as the sixth address bit, and all 64 words can be reached without any outside decoding.

The model is clocked. Every strobe is sampled on `clk`. The data bus is split into `dataIn`, `dataOut` and the drive enable `dataOutEn`, and the three-state pad driver is built from these at the chip edge. Two chip selects of opposite polarity qualify every access. `chainEn` is raised whenever this memory is not fully selected, which lets the next memory on a daisy chain respond.

Mode is decided for each access. If `addrStrobe` is high during the access, the plain-address rules apply. If it is low, the multiplexed rules apply: the access uses the latched select, and the sixth address bit is forced to 0. In multiplexed mode, therefore, only words 0 to 31 can be reached.

Top module: `mux_addr_ram`

## Requirements
- R1: While reset is active and after it ends, `dataOutEn` is 0 and the select latch holds 0. A multiplexed-mode access right after reset therefore finds the device unselected.
- R2: In plain mode (`addrStrobe` = 1), the word address is {`selAddrPin`, `addrLo`}. Each of the 64 words stores and returns its own value.
- R3: A write stores `dataIn` at the first clock edge where `writeStrobeN` is sampled low and was sampled high at the previous edge, with the device fully selected. Holding the strobe low does not write again.
- R4: Writes are ignored when `selHigh` = 0 or `selLowN` = 1.
- R5: `dataOutEn` is 1 only while the device is fully selected, `readStrobeN` = 0 and `writeStrobeN` = 1. When it is 1, `dataOut` carries the addressed word.
- R6: In multiplexed mode, the select latch takes `selAddrPin` at every clock edge where `addrStrobe` is high and holds it while the strobe is low. An access needs the latched value to be 1.
- R7: In multiplexed mode, the word address is {0, `addrLo`}.
- R8: `chainEn` is 1 exactly when the device is not fully selected.
- R9: While `writeStrobeN` = 0, the bus is never driven, even with `readStrobeN` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset |
| addrLo | input | 5 | Dedicated address bits 4..0 |
| selAddrPin | input | 1 | Latched select (multiplexed) or address bit 5 (plain) |
| addrStrobe | input | 1 | Captures the select pin while high; held high for plain mode |
| selHigh | input | 1 | Active-high chip select |
| selLowN | input | 1 | Active-low chip select |
| readStrobeN | input | 1 | Active-low read strobe |
| writeStrobeN | input | 1 | Active-low write strobe |
| dataIn | input | 8 | Bus value seen by the pad |
| dataOut | output | 8 | Read data toward the pad |
| dataOutEn | output | 1 | Pad drive enable |
| chainEn | output | 1 | High when this device is not selected |

## Verification
The bench targets three corners:
- Writing word 37 in plain mode and then reading address 5 in multiplexed mode. A design that kept bit 5 in multiplexed mode would return word 37 instead of word 5.
- Letting the select pin go high after the strobe falls, while the latch held 0. A transparent latch would wrongly select the device, drive the bus and accept a write.
- Holding the write strobe low while the data changes, and driving both strobes low together. A level-sensitive write would store the last value instead of the first, and a missing write interlock would drive the bus against the writer.

// File: rtl/mar_pkg.sv
package mar_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int LO_W   = ADDR_W - 1;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              driveEn;
    logic              wrEn;
    logic [ADDR_W-1:0] wordAddr;
  } ramStrobes_t;
endpackage

// File: rtl/mar_ctrl.sv
module mar_ctrl
  import mar_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [LO_W-1:0] addrLo,
  input  logic            selAddrPin,
  input  logic            addrStrobe,
  input  logic            selHigh,
  input  logic            selLowN,
  input  logic            readStrobeN,
  input  logic            writeStrobeN,
  output ramStrobes_t     strobes,
  output logic            chainEn
);
  logic selLatch;
  logic wrPrevN;
  logic plainMode;
  logic pinSelOk;
  logic fullSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selLatch <= 1'b0;
      wrPrevN  <= 1'b1;
    end else begin
      if (addrStrobe) selLatch <= selAddrPin;
      wrPrevN <= writeStrobeN;
    end
  end

  always_comb begin
    plainMode        = addrStrobe;
    pinSelOk         = plainMode | selLatch;
    fullSel          = selHigh & ~selLowN & pinSelOk;
    strobes.wordAddr = {plainMode & selAddrPin, addrLo};
    strobes.driveEn  = fullSel & ~readStrobeN & writeStrobeN;
    strobes.wrEn     = fullSel & ~writeStrobeN & wrPrevN;
    chainEn          = ~fullSel;
  end

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(addrStrobe) |-> $stable(selLatch));

  // R3
  write_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> !strobes.wrEn);
endmodule

// File: rtl/mar_datapath.sv
module mar_datapath
  import mar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  logic [DATA_W-1:0] words [DEPTH];
  logic [DATA_W-1:0] rdWord;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (strobes.wrEn && strobes.wordAddr == ADDR_W'(w)) words[w] <= dataIn;
    end
  end

  always_comb begin
    rdWord    = words[strobes.wordAddr];
    dataOutEn = strobes.driveEn;
    dataOut   = strobes.driveEn ? rdWord : '0;
  end

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataOutEn && strobes.wrEn));
endmodule

// File: rtl/mux_addr_ram.sv
module mux_addr_ram
  import mar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LO_W-1:0]   addrLo,
  input  logic              selAddrPin,
  input  logic              addrStrobe,
  input  logic              selHigh,
  input  logic              selLowN,
  input  logic              readStrobeN,
  input  logic              writeStrobeN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              chainEn
);
  ramStrobes_t strobes;

  mar_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .addrLo(addrLo), .selAddrPin(selAddrPin),
    .addrStrobe(addrStrobe), .selHigh(selHigh), .selLowN(selLowN),
    .readStrobeN(readStrobeN), .writeStrobeN(writeStrobeN),
    .strobes(strobes), .chainEn(chainEn)
  );

  mar_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  // R5
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobeN || !writeStrobeN || !selHigh || selLowN) |-> !dataOutEn);

  // R8
  chain_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> !chainEn);

  // R4
  write_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> (selHigh && !selLowN && !chainEn));
endmodule

// File: tb/mux_addr_ram_test.sv
`timescale 1ns/1ps
module mux_addr_ram_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] addrLo = '0;
  logic       selAddrPin = 1'b0;
  logic       addrStrobe = 1'b0;
  logic       selHigh = 1'b0;
  logic       selLowN = 1'b1;
  logic       readStrobeN = 1'b1;
  logic       writeStrobeN = 1'b1;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOutEn;
  logic       chainEn;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  mux_addr_ram uut (
    .clk(clk), .rstN(rstN), .addrLo(addrLo), .selAddrPin(selAddrPin),
    .addrStrobe(addrStrobe), .selHigh(selHigh), .selLowN(selLowN),
    .readStrobeN(readStrobeN), .writeStrobeN(writeStrobeN), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .chainEn(chainEn)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input int a);
    return 8'(a * 7) ^ 8'h5A;
  endfunction

  task automatic plainAddr(input int a);
    @(negedge clk);
    addrStrobe = 1'b1; selAddrPin = a[5]; addrLo = a[4:0];
  endtask

  task automatic muxAddr(input logic csBit, input logic pinAfter, input int lo);
    @(negedge clk);
    addrStrobe = 1'b1; selAddrPin = csBit;
    @(negedge clk);
    addrStrobe = 1'b0; selAddrPin = pinAfter; addrLo = lo[4:0];
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); dataIn = d; writeStrobeN = 1'b0;
    @(negedge clk); writeStrobeN = 1'b1;
  endtask

  task automatic doRead(output logic en, output logic [7:0] q, output logic ce);
    @(negedge clk); readStrobeN = 1'b0;
    #1; en = dataOutEn; q = dataOut; ce = chainEn;
    readStrobeN = 1'b1;
  endtask

  task automatic testReset();
    #1;
    check(dataOutEn == 1'b0, "R1 oe during reset", dataOutEn, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1; selHigh = 1'b1; selLowN = 1'b0;
    #1;
    check(chainEn == 1'b1, "R1 latch cleared", chainEn, 1);
    readStrobeN = 1'b0; #1;
    check(dataOutEn == 1'b0, "R1 no drive after reset", dataOutEn, 0);
    readStrobeN = 1'b1;
  endtask

  task automatic testPlainFill();
    logic en, ce; logic [7:0] q;
    for (int a = 0; a < 64; a++) begin
      plainAddr(a); doWrite(pattern(a));
    end
    for (int a = 0; a < 64; a++) begin
      plainAddr(a); doRead(en, q, ce);
      check(en && q == pattern(a), "R2 plain readback", q, pattern(a));
    end
    check(ce == 1'b0, "R8 chain low when selected", ce, 0);
  endtask

  task automatic testDeselect();
    logic en, ce; logic [7:0] q;
    plainAddr(10);
    selHigh = 1'b0; doWrite(8'hEE);
    #1; check(chainEn == 1'b1, "R8 chain high selHigh low", chainEn, 1);
    doRead(en, q, ce);
    check(en == 1'b0, "R5 no drive selHigh low", en, 0);
    selHigh = 1'b1; selLowN = 1'b1; doWrite(8'hDD);
    doRead(en, q, ce);
    check(en == 1'b0, "R5 no drive selLowN high", en, 0);
    check(ce == 1'b1, "R8 chain high selLowN high", ce, 1);
    selLowN = 1'b0;
    doRead(en, q, ce);
    check(q == pattern(10), "R4 deselected writes ignored", q, pattern(10));
  endtask

  task automatic testWriteEdge();
    logic en, ce; logic [7:0] q;
    plainAddr(20);
    @(negedge clk); dataIn = 8'h11; writeStrobeN = 1'b0;
    @(negedge clk); dataIn = 8'h22;
    @(negedge clk); dataIn = 8'h33;
    readStrobeN = 1'b0; #1;
    check(dataOutEn == 1'b0, "R9 no drive while writing", dataOutEn, 0);
    @(negedge clk); writeStrobeN = 1'b1; readStrobeN = 1'b1;
    doRead(en, q, ce);
    check(q == 8'h11, "R3 single write on strobe edge", q, 8'h11);
  endtask

  task automatic testMux();
    logic en, ce; logic [7:0] q;
    muxAddr(1'b1, 1'b1, 5); doRead(en, q, ce);
    check(en && q == pattern(5), "R7 mux bit5 forced low", q, pattern(5));
    muxAddr(1'b1, 1'b0, 3); doWrite(8'hA5);
    muxAddr(1'b1, 1'b1, 3); doRead(en, q, ce);
    check(q == 8'hA5, "R6 mux write selected", q, 8'hA5);
    plainAddr(35); doRead(en, q, ce);
    check(q == pattern(35), "R7 upper word untouched", q, pattern(35));
    muxAddr(1'b0, 1'b1, 7); doRead(en, q, ce);
    check(en == 1'b0, "R6 latched low blocks read", en, 0);
    check(ce == 1'b1, "R8 chain high latched low", ce, 1);
    doWrite(8'h0F);
    muxAddr(1'b1, 1'b0, 7); doRead(en, q, ce);
    check(q == pattern(7), "R6 latched low blocks write", q, pattern(7));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testPlainFill();
    testDeselect();
    testWriteEdge();
    testMux();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule